// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge and End-of-Interrupt Unit

This unit is the delivery side of one processor in a multiprocessor interrupt controller. It holds two sets with one bit per interrupt source. The raised set holds sources waiting to be taken. The in-service set holds sources the processor has taken and not yet retired. It also holds a 4-bit current task priority and an 8-bit spurious vector. The source unit supplies, for every source, a priority, a vector, a level/edge sense flag and an activity flag. It also pulses a raise request when it routes a source to this processor.

Software reads the acknowledge register to take the most urgent raised source and receive its vector. The unit checks the chosen source once more against its activity flag and the task priority. When that check fails, it answers with the spurious vector. It tells the source unit which activity and pending flags to clear. A write to the end-of-interrupt register retires the most urgent in-service source. After that write, the request line to the processor is raised again if waiting work outranks what is still in service.

Top module: `cpu_ack_eoi`

## Requirements
- R1: After reset the task priority reads 15, the spurious vector reads 0xFF, both sets are empty, and `irq_o`, `rvalid_o`, `act_clr_o` and `pend_clr_o` are 0.
- R2: A task-priority write (select 0) keeps only write-data bits 3:0. A spurious-vector write (select 4) keeps only bits 7:0. Reading the same select returns the stored value, zero-extended.
- R3: An acknowledge read (select 2) with an empty raised set returns the spurious vector and changes nothing.
- R4: The source chosen from a set is the one with the greatest priority. On equal priority, the lowest source index wins.
- R5: When the chosen raised source is active and its priority exceeds the task priority, an acknowledge returns its 8-bit vector and moves it from the raised set to the in-service set.
- R6: When the chosen raised source is inactive, or its priority does not exceed the task priority, an acknowledge returns the spurious vector and pulses that source's bit on `act_clr_o`.
- R7: Every acknowledge with a non-empty raised set removes the chosen source from the raised set. For an edge source (sense 0), the acknowledge also pulses its bit on both `act_clr_o` and `pend_clr_o`. A valid acknowledge of a level source (sense 1) pulses neither. The pulses are present in the cycle of the read strobe.
- R8: An end-of-interrupt write (select 3) retires the highest-priority in-service source. If the best raised priority then exceeds the best remaining in-service priority, `irq_o` is set.
- R9: A read of select 1 returns the parameter `CPU_IDX`. A read of select 3 returns 0.
- R10: After an acknowledge, `irq_o` is 1 only if some remaining raised source has priority above both the task priority and every in-service priority.
- R11: An end-of-interrupt write with an empty in-service set changes neither set nor `irq_o`.
- R12: A raise request enters the raised set only if the source priority exceeds the task priority. It sets `irq_o` when its priority exceeds the best priority already raised.
- R13: Read data appears on `rdata_o` with `rvalid_o` high in the cycle after the read strobe. `irq_o` changes one cycle after the event that moves it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_prio_i | input | NUM_SRC*PRIO_W | Priority per source, source i at bits i*PRIO_W |
| src_vec_i | input | NUM_SRC*VEC_W | Vector per source |
| src_level_i | input | NUM_SRC | 1 = level-sensitive, 0 = edge-sensitive |
| src_active_i | input | NUM_SRC | Activity flag per source |
| raise_i | input | NUM_SRC | One-cycle raise request per source |
| reg_rd_i | input | 1 | Register read strobe |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | 0 task priority, 1 identity, 2 acknowledge, 3 end-of-interrupt, 4 spurious vector |
| reg_wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data |
| rvalid_o | output | 1 | Read data valid |
| act_clr_o | output | NUM_SRC | Activity clear pulse to the source unit |
| pend_clr_o | output | NUM_SRC | Pending clear pulse to the source unit |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest state to reach is nested service in which an end-of-interrupt must not re-raise. A raised source has to sit at exactly the priority of the remaining in-service source, so the strict comparison decides. The stimulus builds this by raising two equal-priority sources and acknowledging one. It then raises and acknowledges a higher source on top. The first end-of-interrupt must leave the request low, and the second must raise it. The spurious paths are reached by clearing a source's activity input before it is acknowledged. A second path raises the task priority after a source has already been raised.

// File: rtl/cpu_ack_pkg.sv
package cpu_ack_pkg;
  typedef enum logic [2:0] {
    SEL_TASKPRI = 3'd0,
    SEL_IDENT   = 3'd1,
    SEL_ACK     = 3'd2,
    SEL_EOI     = 3'd3,
    SEL_SPUR    = 3'd4
  } acc_sel_e;
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
  parameter int N  = 16,
  parameter int PW = 5
) (
  input  logic [N-1:0]    set_i,
  input  logic [N*PW-1:0] prio_i,
  output logic            found_o,
  output logic [N-1:0]    hit_o,
  output logic [PW-1:0]   best_o
);
  // upward scan, strict greater replaces: ties resolve to lowest index
  always_comb begin
    found_o = 1'b0;
    hit_o   = '0;
    best_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (set_i[i] && (!found_o || prio_i[i*PW +: PW] > best_o)) begin
        found_o  = 1'b1;
        best_o   = prio_i[i*PW +: PW];
        hit_o    = '0;
        hit_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/cpu_regs.sv
module cpu_regs #(
  parameter int TP_W   = 4,
  parameter int SV_W   = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tp_we_i,
  input  logic              sv_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [TP_W-1:0]   tp_o,
  output logic [SV_W-1:0]   sv_o
);
  logic [TP_W-1:0] tp_q, tp_d;
  logic [SV_W-1:0] sv_q, sv_d;

  always_comb begin
    tp_d = tp_q;
    sv_d = sv_q;
    if (tp_we_i) tp_d = wdata_i[TP_W-1:0];
    if (sv_we_i) sv_d = wdata_i[SV_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tp_q <= '1;
      sv_q <= '1;
    end else begin
      tp_q <= tp_d;
      sv_q <= sv_d;
    end
  end

  assign tp_o = tp_q;
  assign sv_o = sv_q;
endmodule

// File: rtl/cpu_ack_eoi.sv
module cpu_ack_eoi
  import cpu_ack_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 5,
  parameter int VEC_W   = 8,
  parameter int TP_W    = 4,
  parameter int DATA_W  = 32,
  parameter int CPU_IDX = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio_i,
  input  logic [NUM_SRC*VEC_W-1:0]  src_vec_i,
  input  logic [NUM_SRC-1:0]        src_level_i,
  input  logic [NUM_SRC-1:0]        src_active_i,
  input  logic [NUM_SRC-1:0]        raise_i,
  input  logic                      reg_rd_i,
  input  logic                      reg_wr_i,
  input  logic [2:0]                reg_sel_i,
  input  logic [DATA_W-1:0]         reg_wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  output logic                      rvalid_o,
  output logic [NUM_SRC-1:0]        act_clr_o,
  output logic [NUM_SRC-1:0]        pend_clr_o,
  output logic                      irq_o
);
  localparam int SV_W = VEC_W;

  acc_sel_e sel;
  assign sel = acc_sel_e'(reg_sel_i);

  logic rd_ack, wr_eoi;
  assign rd_ack = reg_rd_i && (sel == SEL_ACK);
  assign wr_eoi = reg_wr_i && (sel == SEL_EOI);

  logic [TP_W-1:0] tp;
  logic [SV_W-1:0] spur;
  logic [PRIO_W-1:0] tp_ext;
  assign tp_ext = PRIO_W'(tp);

  cpu_regs #(.TP_W(TP_W), .SV_W(SV_W), .DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .tp_we_i (reg_wr_i && (sel == SEL_TASKPRI)),
    .sv_we_i (reg_wr_i && (sel == SEL_SPUR)),
    .wdata_i (reg_wdata_i),
    .tp_o    (tp),
    .sv_o    (spur)
  );

  logic [NUM_SRC-1:0] raised_q, raised_d, isr_q, isr_d;
  logic               irq_q, irq_d;
  logic [DATA_W-1:0]  rdata_q, rdata_d;
  logic               rvalid_q;

  // current winners
  logic r_found, i_found;
  logic [NUM_SRC-1:0] r_hit, i_hit;
  logic [PRIO_W-1:0]  r_best, i_best;

  prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_raised (
    .set_i(raised_q), .prio_i(src_prio_i),
    .found_o(r_found), .hit_o(r_hit), .best_o(r_best));
  prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_isr (
    .set_i(isr_q), .prio_i(src_prio_i),
    .found_o(i_found), .hit_o(i_hit), .best_o(i_best));

  // attributes of the raised winner
  logic             win_active, win_level, ack_ok;
  logic [VEC_W-1:0] win_vec;
  always_comb begin
    win_vec = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (r_hit[i]) win_vec = src_vec_i[i*VEC_W +: VEC_W];
  end
  assign win_active = |(r_hit & src_active_i);
  assign win_level  = |(r_hit & src_level_i);
  assign ack_ok     = r_found && win_active && (r_best > tp_ext);

  // sets as they would stand after an acknowledge or a retirement
  logic [NUM_SRC-1:0] raised_ack, isr_ack, isr_eoi;
  assign raised_ack = raised_q & ~r_hit;
  assign isr_ack    = ack_ok ? (isr_q | r_hit) : isr_q;
  assign isr_eoi    = isr_q & ~i_hit;

  logic ra_found, ia_found, ie_found;
  logic [NUM_SRC-1:0] ra_hit, ia_hit, ie_hit;
  logic [PRIO_W-1:0]  ra_best, ia_best, ie_best;

  prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_raised_ack (
    .set_i(raised_ack), .prio_i(src_prio_i),
    .found_o(ra_found), .hit_o(ra_hit), .best_o(ra_best));
  prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_isr_ack (
    .set_i(isr_ack), .prio_i(src_prio_i),
    .found_o(ia_found), .hit_o(ia_hit), .best_o(ia_best));
  prio_pick #(.N(NUM_SRC), .PW(PRIO_W)) u_pick_isr_eoi (
    .set_i(isr_eoi), .prio_i(src_prio_i),
    .found_o(ie_found), .hit_o(ie_hit), .best_o(ie_best));

  // raise acceptance against task priority
  logic [NUM_SRC-1:0] raise_ok;
  logic               raise_hi;
  always_comb begin
    raise_hi = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      raise_ok[i] = raise_i[i] && (src_prio_i[i*PRIO_W +: PRIO_W] > tp_ext);
      if (raise_ok[i] && (!r_found || src_prio_i[i*PRIO_W +: PRIO_W] > r_best))
        raise_hi = 1'b1;
    end
  end

  // next state
  always_comb begin
    raised_d = raised_q;
    isr_d    = isr_q;
    irq_d    = irq_q;
    if (rd_ack && r_found) begin
      raised_d = raised_ack;
      isr_d    = isr_ack;
      irq_d    = ra_found && (ra_best > tp_ext) && (!ia_found || ra_best > ia_best);
    end else if (wr_eoi && i_found) begin
      isr_d = isr_eoi;
      if (r_found && (!ie_found || r_best > ie_best)) irq_d = 1'b1;
    end
    raised_d = raised_d | raise_ok;
    if (raise_hi) irq_d = 1'b1;
  end

  always_comb begin
    unique case (sel)
      SEL_TASKPRI: rdata_d = DATA_W'(tp);
      SEL_IDENT:   rdata_d = DATA_W'(CPU_IDX);
      SEL_ACK:     rdata_d = ack_ok ? DATA_W'(win_vec) : DATA_W'(spur);
      SEL_EOI:     rdata_d = '0;
      SEL_SPUR:    rdata_d = DATA_W'(spur);
      default:     rdata_d = '1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raised_q <= '0;
      isr_q    <= '0;
      irq_q    <= 1'b0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      raised_q <= raised_d;
      isr_q    <= isr_d;
      irq_q    <= irq_d;
      rvalid_q <= reg_rd_i;
      if (reg_rd_i) rdata_q <= rdata_d;
    end
  end

  // clear pulses toward the source unit, in the cycle of the read strobe
  logic take;
  assign take       = rd_ack && r_found;
  assign act_clr_o  = (take && (!ack_ok || !win_level)) ? r_hit : '0;
  assign pend_clr_o = (take && !win_level) ? r_hit : '0;

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/cpu_ack_eoi_chk.sv
module cpu_ack_eoi_chk #(
  parameter int NUM_SRC = 16,
  parameter int DATA_W  = 32,
  parameter int CPU_IDX = 0
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] raise_i,
  input logic               reg_rd_i,
  input logic               reg_wr_i,
  input logic [2:0]         reg_sel_i,
  input logic [DATA_W-1:0]  rdata_o,
  input logic               rvalid_o,
  input logic [NUM_SRC-1:0] act_clr_o,
  input logic [NUM_SRC-1:0] pend_clr_o,
  input logic               irq_o
);
  assert_clr_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act_clr_o));

  assert_pend_implies_act_R7: assert property (@(posedge clk) disable iff (!rst_n)
    |pend_clr_o |-> ((pend_clr_o & ~act_clr_o) == '0));

  assert_clr_only_on_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    |act_clr_o |-> (reg_rd_i && reg_sel_i == 3'd2));

  assert_irq_fall_on_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_o) |-> $past(reg_rd_i && reg_sel_i == 3'd2));

  assert_irq_rise_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past((|raise_i) || (reg_wr_i && reg_sel_i == 3'd3)));

  assert_rvalid_follows_R13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_i |=> rvalid_o);

  assert_ident_value_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i == 3'd1) |=> (rdata_o == DATA_W'(CPU_IDX)));

  assert_eoi_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_i && reg_sel_i == 3'd3) |=> (rdata_o == '0));
endmodule

bind cpu_ack_eoi cpu_ack_eoi_chk #(
  .NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .CPU_IDX(CPU_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .reg_rd_i(reg_rd_i),
  .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i), .rdata_o(rdata_o),
  .rvalid_o(rvalid_o), .act_clr_o(act_clr_o), .pend_clr_o(pend_clr_o),
  .irq_o(irq_o)
);

// File: tb/cpu_ack_eoi_tb_top.sv
module cpu_ack_eoi_tb_top;
  localparam int N   = 16;
  localparam int PW  = 5;
  localparam int VW  = 8;
  localparam int DW  = 32;
  localparam int IDX = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N*PW-1:0] src_prio;
  logic [N*VW-1:0] src_vec;
  logic [N-1:0] src_level, src_active, raise;
  logic reg_rd, reg_wr;
  logic [2:0] reg_sel;
  logic [DW-1:0] wdata, rdata;
  logic rvalid, irq;
  logic [N-1:0] act_clr, pend_clr;

  always #5 clk = ~clk;

  cpu_ack_eoi #(.NUM_SRC(N), .PRIO_W(PW), .VEC_W(VW), .TP_W(4), .DATA_W(DW),
                .CPU_IDX(IDX)) dut_i (
    .clk(clk), .rst_n(rst_n), .src_prio_i(src_prio), .src_vec_i(src_vec),
    .src_level_i(src_level), .src_active_i(src_active), .raise_i(raise),
    .reg_rd_i(reg_rd), .reg_wr_i(reg_wr), .reg_sel_i(reg_sel),
    .reg_wdata_i(wdata), .rdata_o(rdata), .rvalid_o(rvalid),
    .act_clr_o(act_clr), .pend_clr_o(pend_clr), .irq_o(irq));

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  localparam logic [1:0] OP_RAISE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2;
  localparam logic [2:0] S_TP = 3'd0, S_ID = 3'd1, S_ACK = 3'd2, S_EOI = 3'd3, S_SV = 3'd4;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  sel;
    logic [31:0] data;
    logic [31:0] exp_rd;
    logic        exp_irq;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 20;
  // source priorities: s0=3 s1=7 s2=7 s3=9 s4=2 s5=12 rest 1; vector 0x40+i; only s2 level
  localparam vec_t TBL [NV] = '{
    '{OP_WR,    S_TP,  32'hFFFF_FFF2, 32'h0,  1'b0, 4'd2},  // R2 task priority -> 2
    '{OP_RD,    S_TP,  32'h0,         32'h2,  1'b0, 4'd2},  // R2
    '{OP_WR,    S_SV,  32'h0000_1234, 32'h0,  1'b0, 4'd2},  // R2 spurious -> 0x34
    '{OP_RD,    S_SV,  32'h0,         32'h34, 1'b0, 4'd2},  // R2
    '{OP_RAISE, S_TP,  32'h0010,      32'h0,  1'b0, 4'd12}, // R12 prio 2 not above tp
    '{OP_RD,    S_ACK, 32'h0,         32'h34, 1'b0, 4'd3},  // R3 empty -> spurious
    '{OP_RAISE, S_TP,  32'h0006,      32'h0,  1'b1, 4'd12}, // R12 s1,s2
    '{OP_RD,    S_ACK, 32'h0,         32'h41, 1'b0, 4'd4},  // R4 tie -> s1, R10 irq low
    '{OP_RAISE, S_TP,  32'h0008,      32'h0,  1'b1, 4'd12}, // R12 s3 outranks
    '{OP_RD,    S_ACK, 32'h0,         32'h43, 1'b0, 4'd10}, // R10 s2(7) under s3(9)
    '{OP_WR,    S_EOI, 32'h0,         32'h0,  1'b0, 4'd8},  // R8 retire s3, 7 !> 7
    '{OP_WR,    S_EOI, 32'h0,         32'h0,  1'b1, 4'd8},  // R8 retire s1, re-raise
    '{OP_RD,    S_ACK, 32'h0,         32'h42, 1'b0, 4'd5},  // R5 level s2
    '{OP_WR,    S_EOI, 32'h0,         32'h0,  1'b0, 4'd8},  // R8
    '{OP_WR,    S_EOI, 32'h0,         32'h0,  1'b0, 4'd11}, // R11 empty in-service
    '{OP_RAISE, S_TP,  32'h0001,      32'h0,  1'b1, 4'd12}, // R12
    '{OP_RD,    S_ACK, 32'h0,         32'h40, 1'b0, 4'd5},  // R5
    '{OP_WR,    S_EOI, 32'h0,         32'h0,  1'b0, 4'd8},  // R8
    '{OP_RD,    S_ID,  32'h0,         32'h3,  1'b0, 4'd9},  // R9 identity
    '{OP_RD,    S_EOI, 32'h0,         32'h0,  1'b0, 4'd9}   // R9 eoi reads zero
  };

  task automatic check(input int req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic op_begin(input logic [1:0] op, input logic [2:0] sel,
                          input logic [31:0] data);
    @(negedge clk);
    reg_sel = sel;
    case (op)
      OP_RAISE: raise = data[N-1:0];
      OP_RD:    reg_rd = 1'b1;
      default:  begin reg_wr = 1'b1; wdata = data; end
    endcase
    #1;
  endtask

  task automatic op_end();
    @(negedge clk);
    raise = '0; reg_rd = 1'b0; reg_wr = 1'b0; wdata = '0;
  endtask

  function automatic logic [PW-1:0] prio_of(input int i);
    case (i)
      0: return 5'd3;  1: return 5'd7;  2: return 5'd7;
      3: return 5'd9;  4: return 5'd2;  5: return 5'd12;
      default: return 5'd1;
    endcase
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      src_prio[i*PW +: PW] = prio_of(i);
      src_vec[i*VW +: VW]  = VW'(8'h40 + i);
    end
    src_level = 16'h0004;
    src_active = '1;
    raise = '0; reg_rd = 1'b0; reg_wr = 1'b0; reg_sel = '0; wdata = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(1, "irq after reset", 32'(irq), 32'h0);
    check(1, "rvalid after reset", 32'(rvalid), 32'h0);
    check(1, "act_clr after reset", 32'(act_clr), 32'h0);
    check(1, "pend_clr after reset", 32'(pend_clr), 32'h0);
    op_begin(OP_RD, S_TP, 0); op_end();
    check(1, "task priority reset", rdata, 32'hF);
    op_begin(OP_RD, S_SV, 0); op_end();
    check(1, "spurious reset", rdata, 32'hFF);

    for (int k = 0; k < NV; k++) begin
      op_begin(TBL[k].op, TBL[k].sel, TBL[k].data);
      op_end();
      if (TBL[k].op == OP_RD) begin
        check(int'(TBL[k].req), $sformatf("step %0d rdata", k), rdata, TBL[k].exp_rd);
        check(13, $sformatf("step %0d rvalid", k), 32'(rvalid), 32'h1);
      end
      check(int'(TBL[k].req), $sformatf("step %0d irq", k), 32'(irq), 32'(TBL[k].exp_irq));
    end

    // R7 edge source valid acknowledge pulses both clears
    op_begin(OP_RAISE, S_TP, 32'h0002); op_end();
    op_begin(OP_RD, S_ACK, 0);
    check(7, "edge ack act_clr", 32'(act_clr), 32'h0002);
    check(7, "edge ack pend_clr", 32'(pend_clr), 32'h0002);
    op_end();
    check(5, "edge ack vector", rdata, 32'h41);
    op_begin(OP_WR, S_EOI, 0); op_end();

    // R7 level source valid acknowledge pulses nothing
    op_begin(OP_RAISE, S_TP, 32'h0004); op_end();
    op_begin(OP_RD, S_ACK, 0);
    check(7, "level ack act_clr", 32'(act_clr), 32'h0);
    check(7, "level ack pend_clr", 32'(pend_clr), 32'h0);
    op_end();
    check(5, "level ack vector", rdata, 32'h42);
    op_begin(OP_WR, S_EOI, 0); op_end();

    // R6 inactive source gives spurious
    src_active[3] = 1'b0;
    op_begin(OP_RAISE, S_TP, 32'h0008); op_end();
    check(12, "raise s3 irq", 32'(irq), 32'h1);
    op_begin(OP_RD, S_ACK, 0);
    check(6, "inactive act_clr", 32'(act_clr), 32'h0008);
    check(7, "inactive edge pend_clr", 32'(pend_clr), 32'h0008);
    op_end();
    check(6, "inactive spurious", rdata, 32'h34);
    check(10, "inactive irq", 32'(irq), 32'h0);
    src_active[3] = 1'b1;

    // R6 priority no longer above task priority
    op_begin(OP_RAISE, S_TP, 32'h0020); op_end();
    check(12, "raise s5 irq", 32'(irq), 32'h1);
    op_begin(OP_WR, S_TP, 32'hC); op_end();
    op_begin(OP_RD, S_ACK, 0);
    check(6, "low prio act_clr", 32'(act_clr), 32'h0020);
    op_end();
    check(6, "low prio spurious", rdata, 32'h34);
    check(10, "low prio irq", 32'(irq), 32'h0);

    // R11 retirement with empty in-service set, then empty acknowledge
    op_begin(OP_WR, S_EOI, 0); op_end();
    check(11, "empty eoi irq", 32'(irq), 32'h0);
    op_begin(OP_RD, S_ACK, 0);
    check(11, "empty eoi then ack act_clr", 32'(act_clr), 32'h0);
    op_end();
    check(3, "ack after empty eoi", rdata, 32'h34);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R13 watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule